// File: doc/BRIEF.md
# Serial EEPROM Target Model (SPI Mode 0)

This block behaves as a small serial EEPROM seen from an SPI controller running in mode 0: clock idle low, data in on the rising clock edge, data out on the falling edge, most significant bit first. A byte-wide array is held on chip, alongside a status byte that holds a busy flag, a write-enable latch, two block-protect bits and a protect-enable bit. Every transaction begins with a one-byte opcode. For data commands, an address of one, two or three bytes follows, most significant byte first.

The SPI pins are oversampled by a system clock, so the whole model lives in one clock domain. An accepted page write is first collected in a page buffer. It is copied into the array when chip select rises, and a programmable busy period starts at that moment. While the busy period runs, only status reads are answered. The write-enable latch must be set before any write is accepted, and it clears again when the write finishes. When the address is one byte wide, bit 3 of the opcode supplies address bit 8. Opcodes 0x0B and 0x0A therefore reach the upper 256 bytes.

Top module: `eeprom_spi_target`

## Requirements
- R1: MISO is driven (`spi_miso_oe` = 1) only while chip select is low. MOSI is sampled on rising SCK and MISO is updated on falling SCK, MSB first. An opcode outside the decoded set is ignored.
- R2: The status byte is {protect-enable, 0, 0, 0, BP1, BP0, write-enable latch, busy}, bits 7 down to 0. It reads 0x00 after reset. Opcode 0x05 returns it in every byte that follows until chip select rises.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it.
- R4: A data write (0x02) or a status write (0x01) issued while the latch is clear leaves the array and the status unchanged.
- R5: The address is ADDR_BYTES bytes, MSB first. With ADDR_BYTES = 1, opcode bit 3 is address bit 8: 0x0B reads and 0x0A writes the upper 256 bytes.
- R6: A data read (0x03) returns consecutive bytes starting at the address for as long as chip select stays low, and crosses page boundaries.
- R7: During a data write the address wraps inside its PAGE_BYTES-aligned page. Bytes past the page end land at the start of the same page, and the next page is never touched.
- R8: Raising chip select after an accepted write (at least one complete data byte, or one status byte) sets busy (status bit 0) for BUSY_CYCLES clocks. During that time every opcode except 0x05 is ignored, and a data read returns 0x00. The latch clears when busy ends.
- R9: BP1:BP0 protect a region: 01 the top quarter, 10 the top half, 11 the whole array. A write whose address falls in that region is discarded, does not start busy, and still clears the latch.
- R10: While protect-enable (status bit 7) is 1, a status write cannot change BP1:BP0 but can change protect-enable.
- R11: A status write changes only bits 7, 3 and 2. The data in bits 1 and 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| spi_miso_oe | output | 1 | Output enable for MISO, high while selected |

## Verification
The assertions assume that SCK idles low when chip select falls, and that chip select and SCK never change in the same system clock cycle. They also assume each SCK half period spans at least four system clocks, so that a byte boundary is decoded before the next falling edge. The stimulus keeps to these conditions: SCK half periods are eight clocks long, chip select moves half a period away from any SCK edge, and reset is applied with chip select high. Every byte the model writes into the array is written before it is read, so no check depends on the array's contents at power-up.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [7:0] OP_WEL_SET  = 8'h06;
  localparam logic [7:0] OP_WEL_CLR  = 8'h04;
  localparam logic [7:0] OP_STAT_RD  = 8'h05;
  localparam logic [7:0] OP_STAT_WR  = 8'h01;
  localparam logic [7:0] OP_DATA_RD  = 8'h03;
  localparam logic [7:0] OP_DATA_WR  = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_RD,
    PH_WR,
    PH_SRD,
    PH_SWR,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic sel_start,
  output logic sel_end,
  output logic mosi_s
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] RST_VAL = 3'b010;

  logic [NPIN-1:0] pin_in;
  logic [NPIN-1:0] st1_q, st2_q;
  logic [1:0]      prev_q;

  assign pin_in = {mosi_i, cs_n_i, sck_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1_q[g] <= RST_VAL[g];
        st2_q[g] <= RST_VAL[g];
      end else begin
        st1_q[g] <= pin_in[g];
        st2_q[g] <= st1_q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL[1:0];
    else        prev_q <= st2_q[1:0];
  end

  assign sel       = ~st2_q[1];
  assign sel_start = ~st2_q[1] &  prev_q[1];
  assign sel_end   =  st2_q[1] & ~prev_q[1];
  assign sck_rise  = sel &  st2_q[0] & ~prev_q[0];
  assign sck_fall  = sel & ~st2_q[0] &  prev_q[0];
  assign mosi_s    = st2_q[2];
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       sel_start,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] bit_q, bit_d;
  logic [6:0] rx_q, rx_d;
  logic [7:0] tx_q, tx_d;
  logic       miso_q, miso_d;
  logic       vld_q, vld_d;
  logic [7:0] byte_q, byte_d;

  always_comb begin
    bit_d  = bit_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    miso_d = miso_q;
    vld_d  = 1'b0;
    byte_d = byte_q;
    if (sel_start) begin
      bit_d  = '0;
      tx_d   = '0;
      miso_d = 1'b0;
    end else begin
      if (sck_rise) begin
        rx_d  = {rx_q[5:0], mosi_s};
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          vld_d  = 1'b1;
          byte_d = {rx_q, mosi_s};
        end
      end
      if (sck_fall) begin
        if (bit_q == 3'd0) begin
          miso_d = tx_byte[7];
          tx_d   = {tx_byte[6:0], 1'b0};
        end else begin
          miso_d = tx_q[7];
          tx_d   = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      bit_q  <= bit_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      miso_q <= miso_d;
      vld_q  <= vld_d;
      byte_q <= byte_d;
    end
  end

  assign rx_valid = vld_q;
  assign rx_byte  = byte_q;
  assign miso     = miso_q;
endmodule

// File: rtl/ee_page_array.sv
module ee_page_array #(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  input  logic             buf_we,
  input  logic [PW-1:0]    buf_idx,
  input  logic [7:0]       buf_din,
  input  logic             buf_clr,
  input  logic             commit_go,
  input  logic [AW-PW-1:0] page_base,
  output logic             commit_busy
);
  localparam logic [PW-1:0] LAST_IDX = PW'(PAGE_BYTES - 1);

  logic [7:0]            mem_q  [MEM_BYTES];
  logic [7:0]            pbuf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pval_q, pval_d;
  logic                  cm_act_q, cm_act_d;
  logic [PW-1:0]         cm_idx_q, cm_idx_d;
  logic [AW-PW-1:0]      cm_page_q, cm_page_d;
  logic                  mem_we;

  assign mem_we = cm_act_q & pval_q[cm_idx_q];

  always_comb begin
    pval_d    = pval_q;
    cm_act_d  = cm_act_q;
    cm_idx_d  = cm_idx_q;
    cm_page_d = cm_page_q;
    if (buf_clr) pval_d = '0;
    if (buf_we)  pval_d[buf_idx] = 1'b1;
    if (commit_go) begin
      cm_act_d  = 1'b1;
      cm_idx_d  = '0;
      cm_page_d = page_base;
    end else if (cm_act_q) begin
      pval_d[cm_idx_q] = 1'b0;
      cm_idx_d = cm_idx_q + 1'b1;
      if (cm_idx_q == LAST_IDX) cm_act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pval_q    <= '0;
      cm_act_q  <= 1'b0;
      cm_idx_q  <= '0;
      cm_page_q <= '0;
    end else begin
      pval_q    <= pval_d;
      cm_act_q  <= cm_act_d;
      cm_idx_q  <= cm_idx_d;
      cm_page_q <= cm_page_d;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf_q[buf_idx] <= buf_din;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[{cm_page_q, cm_idx_q}] <= pbuf_q[cm_idx_q];
  end

  assign rd_data     = mem_q[rd_addr];
  assign commit_busy = cm_act_q;
endmodule

// File: rtl/ee_cmd_ctrl.sv
module ee_cmd_ctrl import eeprom_pkg::*; #(
  parameter int ADDR_BYTES  = 1,
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 200,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_start,
  input  logic             sel_end,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic [7:0]       rd_data,
  output logic [7:0]       tx_byte,
  output logic [AW-1:0]    rd_addr,
  output logic             buf_we,
  output logic [PW-1:0]    buf_idx,
  output logic [7:0]       buf_din,
  output logic             buf_clr,
  output logic             commit_go,
  output logic [AW-PW-1:0] page_base,
  output logic             busy,
  output logic             wel
);
  localparam int         ADDR_W  = 8 * ADDR_BYTES;
  localparam int         BCW     = $clog2(BUSY_CYCLES + 1);
  localparam bit         XBIT_EN = (ADDR_BYTES == 1);
  localparam logic [7:0] OP_MASK = XBIT_EN ? 8'hF7 : 8'hFF;
  localparam logic [1:0] ALAST   = 2'(ADDR_BYTES - 1);
  localparam logic [BCW-1:0] BLOAD = BCW'(BUSY_CYCLES);

  phase_t         ph_q, ph_d;
  logic           ohi_q, ohi_d;
  logic [1:0]     ab_q, ab_d;
  logic           isrd_q, isrd_d;
  logic [AW-1:0]  ptr_q, ptr_d;
  logic           gotd_q, gotd_d;
  logic           gots_q, gots_d;
  logic           nwp_q, nwp_d;
  logic [1:0]     nbp_q, nbp_d;
  logic [1:0]     bp_q, bp_d;
  logic           wpen_q, wpen_d;
  logic           wel_q, wel_d;
  logic [BCW-1:0] bc_q, bc_d;

  logic [ADDR_W-1:0] anext;
  logic [7:0]        opm;
  logic [7:0]        status;
  logic [1:0]        top2;
  logic              prot;

  if (XBIT_EN) begin : g_addr1
    assign anext = rx_byte;
  end else begin : g_addrn
    logic [ADDR_W-9:0] hold_q;
    assign anext = {hold_q, rx_byte};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= '0;
      else if (rx_valid && ph_q == PH_ADDR) hold_q <= anext[ADDR_W-9:0];
    end
  end

  assign busy   = (bc_q != '0);
  assign status = {wpen_q, 3'b000, bp_q, wel_q, busy};
  assign opm    = rx_byte & OP_MASK;
  assign top2   = ptr_q[AW-1 -: 2];
  assign prot   = (bp_q == 2'b11) || (bp_q == 2'b10 && top2[1]) ||
                  (bp_q == 2'b01 && top2 == 2'b11);

  always_comb begin
    ph_d = ph_q;  ohi_d = ohi_q;  ab_d = ab_q;  isrd_d = isrd_q;
    ptr_d = ptr_q;  gotd_d = gotd_q;  gots_d = gots_q;
    nwp_d = nwp_q;  nbp_d = nbp_q;  bp_d = bp_q;  wpen_d = wpen_q;
    wel_d = wel_q;  bc_d = bc_q;
    buf_we = 1'b0;  buf_clr = 1'b0;  commit_go = 1'b0;
    buf_idx = ptr_q[PW-1:0];
    buf_din = rx_byte;

    if (busy) begin
      bc_d = bc_q - 1'b1;
      if (bc_q == BCW'(1)) wel_d = 1'b0;
    end

    if (sel_start) begin
      ph_d = PH_OPC;  ab_d = '0;  gotd_d = 1'b0;  gots_d = 1'b0;
    end else if (rx_valid) begin
      case (ph_q)
        PH_OPC: begin
          ohi_d = rx_byte[3];
          ph_d  = PH_SKIP;
          if (busy) begin
            if (rx_byte == OP_STAT_RD) ph_d = PH_SRD;
          end else if (rx_byte == OP_WEL_SET) begin
            wel_d = 1'b1;
          end else if (rx_byte == OP_WEL_CLR) begin
            wel_d = 1'b0;
          end else if (rx_byte == OP_STAT_RD) begin
            ph_d = PH_SRD;
          end else if (rx_byte == OP_STAT_WR) begin
            if (wel_q) ph_d = PH_SWR;
          end else if (opm == OP_DATA_RD) begin
            ph_d = PH_ADDR;  isrd_d = 1'b1;
          end else if (opm == OP_DATA_WR) begin
            if (wel_q) begin
              ph_d = PH_ADDR;  isrd_d = 1'b0;  buf_clr = 1'b1;
            end
          end
        end
        PH_ADDR: begin
          ab_d = ab_q + 2'd1;
          if (ab_q == ALAST) begin
            ptr_d = AW'({(XBIT_EN & ohi_q), anext});
            ph_d  = isrd_q ? PH_RD : PH_WR;
          end
        end
        PH_RD: ptr_d = ptr_q + 1'b1;
        PH_WR: begin
          buf_we = 1'b1;
          gotd_d = 1'b1;
          ptr_d  = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
        end
        PH_SWR: begin
          if (!gots_q) begin
            gots_d = 1'b1;
            nwp_d  = rx_byte[7];
            nbp_d  = rx_byte[3:2];
          end
        end
        default: ;
      endcase
    end else if (sel_end) begin
      ph_d = PH_SKIP;
      if (ph_q == PH_WR && gotd_q) begin
        if (prot) begin
          wel_d = 1'b0;
        end else begin
          commit_go = 1'b1;
          bc_d = BLOAD;
        end
      end else if (ph_q == PH_SWR && gots_q) begin
        wpen_d = nwp_q;
        if (!wpen_q) bp_d = nbp_q;
        bc_d = BLOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_SKIP;  ohi_q <= 1'b0;  ab_q <= '0;  isrd_q <= 1'b0;
      ptr_q <= '0;  gotd_q <= 1'b0;  gots_q <= 1'b0;
      nwp_q <= 1'b0;  nbp_q <= '0;  bp_q <= '0;  wpen_q <= 1'b0;
      wel_q <= 1'b0;  bc_q <= '0;
    end else begin
      ph_q <= ph_d;  ohi_q <= ohi_d;  ab_q <= ab_d;  isrd_q <= isrd_d;
      ptr_q <= ptr_d;  gotd_q <= gotd_d;  gots_q <= gots_d;
      nwp_q <= nwp_d;  nbp_q <= nbp_d;  bp_q <= bp_d;  wpen_q <= wpen_d;
      wel_q <= wel_d;  bc_q <= bc_d;
    end
  end

  always_comb begin
    case (ph_q)
      PH_SRD:  tx_byte = status;
      PH_RD:   tx_byte = rd_data;
      default: tx_byte = 8'h00;
    endcase
  end

  assign rd_addr   = ptr_q;
  assign page_base = ptr_q[AW-1:PW];
  assign wel       = wel_q;
endmodule

// File: rtl/eeprom_spi_target.sv
module eeprom_spi_target #(
  parameter int ADDR_BYTES  = 1,
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic rst_meta_q, rst_n_i;
  logic sck_rise, sck_fall, sel, sel_start, sel_end, mosi_s;
  logic rx_valid;
  logic [7:0] rx_byte, tx_byte, rd_data, buf_din;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] buf_idx;
  logic [AW-PW-1:0] page_base;
  logic buf_we, buf_clr, commit_go;
  logic busy_w, wel_w, commit_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_i    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_i    <= rst_meta_q;
    end
  end

  spi_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n_i), .sck_i(spi_sck), .cs_n_i(spi_cs_n),
    .mosi_i(spi_mosi), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel(sel), .sel_start(sel_start), .sel_end(sel_end), .mosi_s(mosi_s)
  );

  spi_byte_engine u_eng (
    .clk(clk), .rst_n(rst_n_i), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_start(sel_start), .mosi_s(mosi_s), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .miso(spi_miso)
  );

  ee_cmd_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .MEM_BYTES(MEM_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .sel_start(sel_start), .sel_end(sel_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_data(rd_data),
    .tx_byte(tx_byte), .rd_addr(rd_addr), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_din(buf_din), .buf_clr(buf_clr),
    .commit_go(commit_go), .page_base(page_base),
    .busy(busy_w), .wel(wel_w)
  );

  ee_page_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_arr (
    .clk(clk), .rst_n(rst_n_i), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_din(buf_din),
    .buf_clr(buf_clr), .commit_go(commit_go), .page_base(page_base),
    .commit_busy(commit_w)
  );

  assign spi_miso_oe = sel;
endmodule

// File: rtl/eeprom_spi_target_chk.sv
module eeprom_spi_target_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_miso_oe,
  input logic busy_w,
  input logic wel_w,
  input logic commit_w
);
  AST_MISO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_cs_n, 2) |-> !spi_miso_oe);                       // R1

  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_w) |-> wel_w);                                   // R4

  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_w) |-> !wel_w);                                  // R8

  AST_NO_WEL_SET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_w) |-> !$rose(wel_w));                           // R8

  AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |-> busy_w);                                       // R8
endmodule

bind eeprom_spi_target eeprom_spi_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .busy_w(busy_w), .wel_w(wel_w), .commit_w(commit_w)
);

// File: tb/tb_eeprom_spi_target.sv
module tb_eeprom_spi_target;
  localparam int HALF  = 8;
  localparam int BUSY  = 3000;
  localparam int WAITB = BUSY + 100;

  logic clk = 1'b0;
  logic rst_n, spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso, spi_miso_oe;

  typedef struct {
    bit         chk;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  eeprom_spi_target #(
    .ADDR_BYTES(1), .MEM_BYTES(512), .PAGE_BYTES(16), .BUSY_CYCLES(BUSY)
  ) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, input bit chk, input logic [7:0] exp,
                       input string req);
    item_t it;
    it.chk = chk; it.exp = exp; it.req = req;
    q.push_back(it);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      tick(HALF);
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic cs_lo;
    spi_cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_hi;
    tick(HALF);
    spi_cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_lo; xbyte(op, 0, 8'h00, ""); cs_hi;
  endtask

  task automatic stat_rd(input logic [7:0] exp, input string req);
    cs_lo; xbyte(8'h05, 0, 8'h00, ""); xbyte(8'h00, 1, exp, req); cs_hi;
  endtask

  task automatic stat_wr(input logic [7:0] v);
    cs_lo; xbyte(8'h01, 0, 8'h00, ""); xbyte(v, 0, 8'h00, ""); cs_hi;
  endtask

  task automatic wr(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d[$]);
    cs_lo;
    xbyte(op, 0, 8'h00, "");
    xbyte(a, 0, 8'h00, "");
    foreach (d[i]) xbyte(d[i], 0, 8'h00, "");
    cs_hi;
  endtask

  task automatic rd(input logic [7:0] op, input logic [7:0] a, input logic [7:0] e[$],
                    input string req);
    cs_lo;
    xbyte(op, 0, 8'h00, "");
    xbyte(a, 0, 8'h00, "");
    foreach (e[i]) xbyte(8'h00, 1, e[i], req);
    cs_hi;
  endtask

  initial begin : monitor
    logic [7:0] sh;
    int bc;
    item_t it;
    sh = '0;
    bc = 0;
    forever begin
      @(posedge spi_sck);
      if (!spi_cs_n) begin
        sh = {sh[6:0], spi_miso};
        bc++;
        if (bc == 8) begin
          bc = 0;
          if (q.size() > 0) begin
            it = q.pop_front();
            if (it.chk) begin
              n_chk++;
              if (sh !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %02h expected %02h", it.req, sh, it.exp);
              end
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    tick(6);
    rst_n = 1'b1;
    tick(6);

    check_bit(spi_miso_oe, 1'b0, "R1 idle oe");
    stat_rd(8'h00, "R2 reset status");

    cs_lo; tick(4);
    check_bit(spi_miso_oe, 1'b1, "R1 selected oe");
    cs_hi;
    check_bit(spi_miso_oe, 1'b0, "R1 released oe");

    cmd(8'h06); stat_rd(8'h02, "R3 latch set");
    cmd(8'h04); stat_rd(8'h00, "R3 latch cleared");

    cmd(8'h06); wr(8'h02, 8'h10, '{8'h11, 8'h22});
    cs_lo; xbyte(8'h05, 0, 8'h00, "");
    xbyte(8'h00, 1, 8'h03, "R8 busy status");
    xbyte(8'h00, 1, 8'h03, "R2 repeated status");
    cs_hi;
    tick(WAITB);
    stat_rd(8'h00, "R8 latch cleared after busy");

    cmd(8'h06); wr(8'h02, 8'h20, '{8'h55}); tick(WAITB);

    wr(8'h02, 8'h10, '{8'hAA});
    stat_rd(8'h00, "R4 no busy without latch");
    rd(8'h03, 8'h10, '{8'h11, 8'h22}, "R4 R6 data kept");

    cmd(8'h06); wr(8'h02, 8'h1E, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}); tick(WAITB);
    rd(8'h03, 8'h10, '{8'hA2, 8'hA3}, "R7 wrapped bytes");
    rd(8'h03, 8'h1E, '{8'hA0, 8'hA1, 8'h55}, "R7 R6 page end and next page");

    cmd(8'h06); wr(8'h0A, 8'h10, '{8'h5A}); tick(WAITB);
    rd(8'h0B, 8'h10, '{8'h5A}, "R5 upper address");
    rd(8'h03, 8'h10, '{8'hA2}, "R5 lower address untouched");

    cmd(8'h06); wr(8'h02, 8'h30, '{8'h01});
    cmd(8'h06);
    wr(8'h02, 8'h30, '{8'h02});
    rd(8'h03, 8'h30, '{8'h00}, "R8 read ignored while busy");
    tick(WAITB);
    rd(8'h03, 8'h30, '{8'h01}, "R8 write ignored while busy");
    stat_rd(8'h00, "R8 latch request ignored while busy");

    stat_wr(8'h08);
    stat_rd(8'h00, "R4 status write without latch");

    cmd(8'h06); stat_wr(8'h0B); tick(WAITB);
    stat_rd(8'h08, "R11 only bits 7 3 2 written");

    cmd(8'h06); wr(8'h0A, 8'h10, '{8'h77});
    stat_rd(8'h08, "R9 protected write clears latch no busy");
    rd(8'h0B, 8'h10, '{8'h5A}, "R9 protected data kept");
    cmd(8'h06); wr(8'h02, 8'h10, '{8'h66}); tick(WAITB);
    rd(8'h03, 8'h10, '{8'h66}, "R9 lower half writable");

    cmd(8'h06); stat_wr(8'h88); tick(WAITB);
    stat_rd(8'h88, "R10 protect enable set");
    cmd(8'h06); stat_wr(8'h84); tick(WAITB);
    stat_rd(8'h88, "R10 block bits frozen");
    cmd(8'h06); stat_wr(8'h04); tick(WAITB);
    stat_rd(8'h08, "R10 protect enable cleared");
    cmd(8'h06); stat_wr(8'h00); tick(WAITB);
    stat_rd(8'h00, "R10 block bits free again");

    cmd(8'h06);
    cs_lo; xbyte(8'hFF, 0, 8'h00, ""); xbyte(8'h00, 0, 8'h00, ""); cs_hi;
    stat_rd(8'h02, "R1 unknown opcode ignored");
    cmd(8'h04);

    tick(20);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule